// File: doc/BRIEF.md
# Sleep-Mode Clock Gating Controller

This block is the power-management controller of a small 8-bit microcontroller. The CPU gives it a 3-bit sleep-mode select field, a sleep-enable bit and a one-cycle strobe that the sleep instruction raises. When the strobe arrives with the enable bit set, the controller leaves the active state and enters the selected sleep mode. In that mode it drops the clock-enable outputs of every domain the mode does not keep alive. There are six domains: the CPU, the memory and I/O bus, the synchronous peripherals (timers, serial ports, interrupt logic), the ADC, the asynchronous timer and the main crystal oscillator.

Five sleep modes exist, and each keeps its own set of domains alive. In the light mode only the CPU clock stops. In the ADC quiet mode only the ADC, the asynchronous timer and the oscillator stay on. In the deep mode everything stops. The timebase mode keeps only the asynchronous timer. The fast-start mode keeps only the crystal oscillator. A wake-up request ends sleep only if its source is still clocked in the current mode. When that happens, all enables return in one step and the CPU sees a single-cycle wake pulse. The asynchronous reset forces the active state at any time. The controller releases that reset synchronously to the clock.

The outputs are enable levels only. The clock generators and the gates they drive sit outside this block.

Top module: `pmu_sleep_ctrl`

## Requirements
- R1: In the active state (`cur_mode` = 0), a clock edge that sees `sleep_req` = 1 and `sleep_en` = 1 moves the controller into the mode that `mode_sel` selects. The selections are 000 light (`cur_mode` 1), 001 ADC quiet (2), 010 deep (3), 011 timebase (4) and 110 fast-start (5). `sleeping` is 1 in every mode other than 0.
- R2: A `sleep_req` strobe that arrives while `sleep_en` = 0 is ignored. The controller stays in `cur_mode` 0 with all enables at 1.
- R3: The reserved selections 100, 101 and 111 enter the light mode (`cur_mode` 1).
- R4: The domain enables in each mode are as follows. Active: all six at 1. Light: all except `clk_en_cpu`. ADC quiet: `clk_en_adc`, `clk_en_async` and `clk_en_osc` only. Deep: none. Timebase: `clk_en_async` only. Fast-start: `clk_en_osc` only.
- R5: An accepted wake-up returns `cur_mode` to 0 and sets all six enables to 1 on the same clock edge. On that same edge `wake_pulse` goes high for exactly one cycle.
- R6: `wake_ext` ends every sleep mode. `wake_async` ends only the light, ADC quiet and timebase modes. `wake_sync` ends only the light mode. `wake_adc` ends only the light and ADC quiet modes. A wake-up request that does not qualify leaves the mode and its enables unchanged.
- R7: Asserting `rst_n` low forces `cur_mode` 0 with all enables at 1 and `wake_pulse` at 0, whatever the current mode.
- R8: Wake-up inputs that arrive in the active state produce no `wake_pulse` and leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 3 | Sleep-mode select field |
| sleep_en | input | 1 | Sleep permitted |
| sleep_req | input | 1 | Sleep-instruction strobe |
| wake_ext | input | 1 | External pin or reset-class wake-up |
| wake_async | input | 1 | Asynchronous timer interrupt |
| wake_sync | input | 1 | Synchronous peripheral interrupt |
| wake_adc | input | 1 | ADC conversion-complete interrupt |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | Memory and I/O bus clock enable |
| clk_en_periph | output | 1 | Synchronous peripheral clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| clk_en_osc | output | 1 | Main crystal oscillator enable |
| wake_pulse | output | 1 | One-cycle wake indication to the CPU |
| sleeping | output | 1 | High while in any sleep mode |
| cur_mode | output | 3 | Current state code, 0 to 5 |

## Verification
The assertions check several properties on every cycle. A wake pulse always coincides with the active state and full enables, and it never lasts two cycles. The CPU enable is low whenever the controller sleeps. The active state holds unless an enabled strobe arrives. The deep and fast-start modes hold unless the external wake-up arrives. The bench sweeps every mode-select encoding against every wake-up source. Only that sweep can show the full per-mode enable table, the reserved-encoding fallback, the complete qualification matrix and a reset taken from inside sleep.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int MODE_W      = 3;
  localparam int NUM_DOMAINS = 6;
  localparam int NUM_WAKE    = 4;

  // domain bit positions in the enable vector
  localparam int DOM_CPU    = 0;
  localparam int DOM_IO     = 1;
  localparam int DOM_PERIPH = 2;
  localparam int DOM_ADC    = 3;
  localparam int DOM_ASYNC  = 4;
  localparam int DOM_OSC    = 5;

  // wake-up source positions
  localparam int WK_EXT   = 0;
  localparam int WK_ASYNC = 1;
  localparam int WK_SYNC  = 2;
  localparam int WK_ADC   = 3;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_LIGHT   = 3'd1,
    ST_ADCQ    = 3'd2,
    ST_DEEP    = 3'd3,
    ST_TBASE   = 3'd4,
    ST_FSTART  = 3'd5
  } pm_state_t;
endpackage

// File: rtl/pmu_rst_sync.sv
module pmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmu_mode_decode.sv
module pmu_mode_decode
  import pmu_pkg::*;
(
  input  logic [MODE_W-1:0] sel,
  output pm_state_t         target
);
  always_comb begin
    case (sel)
      3'b001:  target = ST_ADCQ;
      3'b010:  target = ST_DEEP;
      3'b011:  target = ST_TBASE;
      3'b110:  target = ST_FSTART;
      default: target = ST_LIGHT;  // 000 and reserved encodings
    endcase
  end
endmodule

// File: rtl/pmu_wake_qual.sv
module pmu_wake_qual
  import pmu_pkg::*;
(
  input  pm_state_t             state,
  input  logic [NUM_WAKE-1:0]   src,
  output logic                  accept
);
  // a source may end a mode only if its clock domain still runs there
  function automatic logic allowed(input int idx, input pm_state_t st);
    logic ok;
    ok = 1'b0;
    case (idx)
      WK_EXT:   ok = (st != ST_ACTIVE);
      WK_ASYNC: ok = (st == ST_LIGHT) || (st == ST_ADCQ) || (st == ST_TBASE);
      WK_SYNC:  ok = (st == ST_LIGHT);
      WK_ADC:   ok = (st == ST_LIGHT) || (st == ST_ADCQ);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  logic [NUM_WAKE-1:0] hit;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
    assign hit[i] = src[i] & allowed(i, state);
  end

  assign accept = |hit;
endmodule

// File: rtl/pmu_domain_map.sv
module pmu_domain_map
  import pmu_pkg::*;
(
  input  pm_state_t               state,
  output logic [NUM_DOMAINS-1:0]  en
);
  always_comb begin
    en = '0;
    case (state)
      ST_ACTIVE: en = '1;
      ST_LIGHT: begin
        en         = '1;
        en[DOM_CPU] = 1'b0;
      end
      ST_ADCQ: begin
        en[DOM_ADC]   = 1'b1;
        en[DOM_ASYNC] = 1'b1;
        en[DOM_OSC]   = 1'b1;
      end
      ST_TBASE:  en[DOM_ASYNC] = 1'b1;
      ST_FSTART: en[DOM_OSC]   = 1'b1;
      default:   en = '0;  // deep mode
    endcase
  end
endmodule

// File: rtl/pmu_sleep_ctrl.sv
module pmu_sleep_ctrl
  import pmu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              sleep_en,
  input  logic              sleep_req,
  input  logic              wake_ext,
  input  logic              wake_async,
  input  logic              wake_sync,
  input  logic              wake_adc,
  output logic              clk_en_cpu,
  output logic              clk_en_io,
  output logic              clk_en_periph,
  output logic              clk_en_adc,
  output logic              clk_en_async,
  output logic              clk_en_osc,
  output logic              wake_pulse,
  output logic              sleeping,
  output logic [2:0]        cur_mode
);
  logic                   srst_n;
  pm_state_t              req_state;
  pm_state_t              state_q, state_d;
  logic                   pulse_q, pulse_d;
  logic                   wake_ok;
  logic [NUM_WAKE-1:0]    wake_vec;
  logic [NUM_DOMAINS-1:0] dom_en;

  pmu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pmu_mode_decode u_dec (
    .sel    (mode_sel),
    .target (req_state)
  );

  always_comb begin
    wake_vec           = '0;
    wake_vec[WK_EXT]   = wake_ext;
    wake_vec[WK_ASYNC] = wake_async;
    wake_vec[WK_SYNC]  = wake_sync;
    wake_vec[WK_ADC]   = wake_adc;
  end

  pmu_wake_qual u_wq (
    .state  (state_q),
    .src    (wake_vec),
    .accept (wake_ok)
  );

  // next state
  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    if (state_q == ST_ACTIVE) begin
      if (sleep_req && sleep_en) state_d = req_state;
    end else if (wake_ok) begin
      state_d = ST_ACTIVE;
      pulse_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_ACTIVE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  pmu_domain_map u_map (
    .state (state_q),
    .en    (dom_en)
  );

  assign clk_en_cpu    = dom_en[DOM_CPU];
  assign clk_en_io     = dom_en[DOM_IO];
  assign clk_en_periph = dom_en[DOM_PERIPH];
  assign clk_en_adc    = dom_en[DOM_ADC];
  assign clk_en_async  = dom_en[DOM_ASYNC];
  assign clk_en_osc    = dom_en[DOM_OSC];
  assign wake_pulse    = pulse_q;
  assign sleeping      = (state_q != ST_ACTIVE);
  assign cur_mode      = state_q;
endmodule

// File: rtl/pmu_sleep_ctrl_chk.sv
module pmu_sleep_ctrl_chk
  import pmu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_en,
  input logic       sleep_req,
  input logic       wake_ext,
  input logic       clk_en_cpu,
  input logic       clk_en_io,
  input logic       clk_en_periph,
  input logic       clk_en_adc,
  input logic       clk_en_async,
  input logic       clk_en_osc,
  input logic       wake_pulse,
  input logic       sleeping,
  input logic [2:0] cur_mode
);
  logic all_on;
  assign all_on = clk_en_cpu & clk_en_io & clk_en_periph &
                  clk_en_adc & clk_en_async & clk_en_osc;

  a_r5_wake_full_enables: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (all_on && !sleeping));

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r4_cpu_off_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !clk_en_cpu);

  a_r2_stay_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && !(sleep_req && sleep_en)) |=> !sleeping);

  a_r6_deep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'(ST_DEEP) && !wake_ext) |=> cur_mode == 3'(ST_DEEP));

  a_r6_fstart_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'(ST_FSTART) && !wake_ext) |=> cur_mode == 3'(ST_FSTART));

  a_r8_no_pulse_active: assert property (@(posedge clk) disable iff (!rst_n)
    !sleeping |=> !wake_pulse);
endmodule

bind pmu_sleep_ctrl pmu_sleep_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_en      (sleep_en),
  .sleep_req     (sleep_req),
  .wake_ext      (wake_ext),
  .clk_en_cpu    (clk_en_cpu),
  .clk_en_io     (clk_en_io),
  .clk_en_periph (clk_en_periph),
  .clk_en_adc    (clk_en_adc),
  .clk_en_async  (clk_en_async),
  .clk_en_osc    (clk_en_osc),
  .wake_pulse    (wake_pulse),
  .sleeping      (sleeping),
  .cur_mode      (cur_mode)
);

// File: tb/pmu_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pmu_sleep_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic       sleep_en, sleep_req;
  logic       wake_ext, wake_async, wake_sync, wake_adc;
  logic       clk_en_cpu, clk_en_io, clk_en_periph, clk_en_adc, clk_en_async, clk_en_osc;
  logic       wake_pulse, sleeping;
  logic [2:0] cur_mode;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pmu_sleep_ctrl u_pmu_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
    .sleep_req(sleep_req), .wake_ext(wake_ext), .wake_async(wake_async),
    .wake_sync(wake_sync), .wake_adc(wake_adc), .clk_en_cpu(clk_en_cpu),
    .clk_en_io(clk_en_io), .clk_en_periph(clk_en_periph), .clk_en_adc(clk_en_adc),
    .clk_en_async(clk_en_async), .clk_en_osc(clk_en_osc), .wake_pulse(wake_pulse),
    .sleeping(sleeping), .cur_mode(cur_mode)
  );

  function automatic logic [5:0] enables();
    return {clk_en_osc, clk_en_async, clk_en_adc, clk_en_periph, clk_en_io, clk_en_cpu};
  endfunction

  // R1/R3: selection -> state code
  function automatic int exp_mode(input int sel);
    case (sel)
      1: return 2;
      2: return 3;
      3: return 4;
      6: return 5;
      default: return 1;
    endcase
  endfunction

  // R4: {osc,async,adc,periph,io,cpu}
  function automatic logic [5:0] exp_en(input int st);
    case (st)
      0: return 6'b111111;
      1: return 6'b111110;
      2: return 6'b111000;
      4: return 6'b010000;
      5: return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

  // R6: source 0 ext, 1 async, 2 sync, 3 adc
  function automatic bit qualifies(input int st, input int src);
    case (src)
      0: return st != 0;
      1: return st == 1 || st == 2 || st == 4;
      2: return st == 1;
      default: return st == 1 || st == 2;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_wake(input int src, input logic v);
    case (src)
      0: wake_ext   = v;
      1: wake_async = v;
      2: wake_sync  = v;
      default: wake_adc = v;
    endcase
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = '0; sleep_en = 0; sleep_req = 0;
    wake_ext = 0; wake_async = 0; wake_sync = 0; wake_adc = 0;
    repeat (3) step();
    check("R7 reset mode", 16'(cur_mode), 16'd0);
    check("R7 reset enables", 16'(enables()), 16'h3f);
    check("R7 reset pulse", 16'(wake_pulse), 16'd0);
    rst_n = 1'b1;
    repeat (4) step();

    // R8: wake inputs while active
    wake_ext = 1; wake_async = 1; wake_sync = 1; wake_adc = 1;
    step();
    check("R8 no pulse active", 16'(wake_pulse), 16'd0);
    check("R8 stays active", 16'(cur_mode), 16'd0);
    wake_ext = 0; wake_async = 0; wake_sync = 0; wake_adc = 0;

    // R2: strobe without enable, every selection
    for (int s = 0; s < 8; s++) begin
      mode_sel = 3'(s); sleep_en = 0; sleep_req = 1;
      step();
      sleep_req = 0;
      check("R2 ignored mode", 16'(cur_mode), 16'd0);
      check("R2 ignored enables", 16'(enables()), 16'h3f);
    end

    // R1 R3 R4 R5 R6: every selection against every source
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 4; w++) begin
        int em;
        em = exp_mode(s);
        mode_sel = 3'(s); sleep_en = 1; sleep_req = 1;
        step();
        sleep_req = 0; sleep_en = 0;
        check((s == 4 || s == 5 || s == 7) ? "R3 reserved to light" : "R1 entry mode",
              16'(cur_mode), 16'(em));
        check("R1 sleeping flag", 16'(sleeping), 16'd1);
        check("R4 domain enables", 16'(enables()), 16'(exp_en(em)));
        set_wake(w, 1'b1);
        step();
        set_wake(w, 1'b0);
        if (qualifies(em, w)) begin
          check("R5 wake mode", 16'(cur_mode), 16'd0);
          check("R5 wake enables", 16'(enables()), 16'h3f);
          check("R5 wake pulse high", 16'(wake_pulse), 16'd1);
          step();
          check("R5 wake pulse one cycle", 16'(wake_pulse), 16'd0);
        end else begin
          check("R6 unqualified holds mode", 16'(cur_mode), 16'(em));
          check("R6 unqualified holds enables", 16'(enables()), 16'(exp_en(em)));
          check("R6 unqualified no pulse", 16'(wake_pulse), 16'd0);
          wake_ext = 1;
          step();
          wake_ext = 0;
          check("R6 ext ends mode", 16'(cur_mode), 16'd0);
          step();
        end
      end
    end

    // R7: reset taken while in deep mode
    mode_sel = 3'b010; sleep_en = 1; sleep_req = 1;
    step();
    sleep_req = 0; sleep_en = 0;
    check("R1 deep entered", 16'(cur_mode), 16'd3);
    rst_n = 1'b0;
    #1;
    check("R7 reset from sleep mode", 16'(cur_mode), 16'd0);
    check("R7 reset from sleep enables", 16'(enables()), 16'h3f);
    step();
    rst_n = 1'b1;
    repeat (3) step();
    check("R7 active after release", 16'(cur_mode), 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule